// File: doc/BRIEF.md
# DRAM Rank Power-State Controller

This block owns the clock-enable (CKE) pin of every rank on a memory channel. Each rank has its own state machine. The machine holds CKE high while the rank carries traffic. When the rank has been idle long enough, the machine drops CKE into one of three low-power conditions:

- a power-down with all banks closed;
- a power-down with at least one bank still open;
- self-refresh, in which the device keeps its own contents alive.

The choice between power-down and self-refresh is not made by the idle timer alone. Self-refresh is taken only when the package sits in a deep idle state (C3, C6 or C7). When the integrated graphics engine is in use, that engine must also be idle and no display fetch may be pending.

The command issuer sits beside this block. From this block it receives a one-cycle request to send the self-refresh entry command, and a one-cycle request to send the exit command. It also receives a per-rank ready flag, which says when commands may be issued to that rank again. Two programmable inputs set the timing: the idle interval that must pass before any low-power entry, and the wait after self-refresh exit before the rank is ready.

Top module: `rank_cke_ctrl`

## Requirements
- R1: During and straight after reset, every rank is active: CKE high, ready high, state code 0, and no entry or exit request.
- R2: An active rank enters a low-power state at the clock edge that sees its (idle_limit+1)-th consecutive quiet cycle. A quiet cycle is one with rank_idle high and rank_req low. Any non-quiet cycle restarts the count.
- R3: When the idle interval expires and self-refresh is not chosen, the rank drops CKE and ready. It reports state code 1 (power-down, banks closed) if bank_open is low, and code 2 (power-down, bank open) if bank_open is high.
- R4: A rank in either power-down state that sees rank_req high or rank_idle low is active again at the next edge, with CKE and ready high and state code 0.
- R5: Self-refresh is permitted only while pkg_state is 3 (C3), 4 (C6) or 5 (C7); codes 0 to 2 (C0, C1, C1E) allow power-down only. While igfx_used is high, permission also requires gfx_idle high and disp_pend low.
- R6: When the idle interval expires with self-refresh permitted and bank_open low, sr_enter_req is high for exactly one cycle, during which CKE stays high and ready is low. On the next cycle CKE is low with state code 3. If bank_open is high, the rank takes code 2 instead.
- R7: A rank in self-refresh leaves it when it stops being quiet or loses permission. sr_exit_req is then high for one cycle, and CKE is high from that cycle on. Ready rises exit_lat+1 cycles after the exit edge.
- R8: A rank in power-down with banks closed that gains self-refresh permission while still quiet returns to active (CKE high) and restarts its idle count. A rank in power-down with a bank open stays there.
- R9: Each rank's CKE, ready, state and requests depend only on that rank's own inputs and the shared package and graphics inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_limit | input | IDLE_W | Idle cycles beyond the first before entry |
| exit_lat | input | XLAT_W | Wait cycles after self-refresh exit before ready |
| rank_req | input | NUM_RANKS | New request targeting each rank |
| rank_idle | input | NUM_RANKS | Rank has no outstanding work |
| bank_open | input | NUM_RANKS | At least one bank of the rank is open |
| pkg_state | input | 3 | Package idle state: 0 C0, 1 C1, 2 C1E, 3 C3, 4 C6, 5 C7 |
| igfx_used | input | 1 | Integrated graphics is in use |
| gfx_idle | input | 1 | Graphics engine idle |
| disp_pend | input | 1 | Display requests pending |
| cke | output | NUM_RANKS | Clock enable per rank |
| rank_ready | output | NUM_RANKS | Rank accepts commands |
| sr_enter_req | output | NUM_RANKS | One-cycle request to issue self-refresh entry |
| sr_exit_req | output | NUM_RANKS | One-cycle request to issue self-refresh exit |
| pwr_state | output | 2*NUM_RANKS | Per-rank code: 0 active/transition, 1 closed-bank power-down, 2 open-bank power-down, 3 self-refresh |

## Verification
The bench targets the following corner cases, each with the failure it would expose:

- **Idle-count restart.** A single busy cycle inside an idle run must restart the count. A design that only pauses the count would enter power-down one edge early.
- **Shallow package states.** With the package in C0 to C1E, a timer expiry must give power-down. A design that ignored the package state would pulse a self-refresh request there.
- **Graphics gating.** The graphics-idle and display-pending flags are each toggled while a rank sits in power-down. Wrong gating would either promote the rank to self-refresh too soon or never promote it.
- **Exit timing.** Self-refresh exit is driven both by traffic and by loss of permission, with exit latencies of 2 and 0. A miscounted wait moves the rise of ready by a cycle.
- **Bank open at expiry.** A rank with an open bank at expiry must take power-down rather than self-refresh. A rank in open-bank power-down must not be promoted when permission arrives.

// File: rtl/rank_cke_pkg.sv
package rank_cke_pkg;

    // Package idle-state codes seen on pkg_state
    typedef enum logic [2:0] {
        PKG_C0  = 3'd0,
        PKG_C1  = 3'd1,
        PKG_C1E = 3'd2,
        PKG_C3  = 3'd3,
        PKG_C6  = 3'd4,
        PKG_C7  = 3'd5
    } pkg_cstate_e;

    // Internal per-rank machine states
    typedef enum logic [2:0] {
        RS_ACTIVE  = 3'd0,
        RS_PD_CLS  = 3'd1,
        RS_PD_OPN  = 3'd2,
        RS_SR_ENT  = 3'd3,
        RS_SR      = 3'd4,
        RS_SR_EXIT = 3'd5
    } rank_state_e;

    // Reported state codes on pwr_state
    localparam logic [1:0] CODE_ACTIVE = 2'd0;
    localparam logic [1:0] CODE_PD_CLS = 2'd1;
    localparam logic [1:0] CODE_PD_OPN = 2'd2;
    localparam logic [1:0] CODE_SR     = 2'd3;

endpackage

// File: rtl/rank_sr_gate.sv
// Self-refresh permission gate.
// Decides whether the current package idle state and the graphics
// and display activity allow any rank to be put in self-refresh.
// Assumes pkg_state holds the codes defined in rank_cke_pkg; unused
// codes are treated as shallow states.
module rank_sr_gate
    import rank_cke_pkg::*;
(
    input  logic [2:0] pkg_state,
    input  logic       igfx_used,
    input  logic       gfx_idle,
    input  logic       disp_pend,
    output logic       sr_ok
);
    logic deep_pkg;
    logic gfx_quiet;

    // Deep package states are the only ones that admit self-refresh
    always_comb begin
        case (pkg_state)
            PKG_C3, PKG_C6, PKG_C7: deep_pkg = 1'b1;
            default:                deep_pkg = 1'b0;
        endcase
    end

    // Graphics must be quiet when it shares the memory
    always_comb begin
        gfx_quiet = !igfx_used || (gfx_idle && !disp_pend);
        sr_ok     = deep_pkg && gfx_quiet;
    end
endmodule

// File: rtl/rank_dwell_cnt.sv
// Dwell counter shared by the idle interval and the exit wait.
// Clears on request, otherwise steps up by one when told to.
// Assumes the owner never asks it to step past its maximum value.
module rank_dwell_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Hold, clear or advance the dwell count
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (inc)      count <= count + 1'b1;
    end
endmodule

// File: rtl/rank_pwr_fsm.sv
// Power-state machine for one rank.
// Walks a rank through active, the two power-down flavours and
// self-refresh, and drives its CKE, ready flag, entry and exit
// pulses and reported state code. Assumes the limits are already
// extended to the counter width and stay stable while in use.
module rank_pwr_fsm
    import rank_cke_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] idle_lim,
    input  logic [CNT_W-1:0] exit_lim,
    input  logic             req,
    input  logic             idle,
    input  logic             bank_open,
    input  logic             sr_ok,
    output logic             cke,
    output logic             ready,
    output logic             sr_enter,
    output logic             sr_exit,
    output logic [1:0]       code
);
    rank_state_e       state, nxt;
    logic              cnt_clr, cnt_inc;
    logic [CNT_W-1:0]  cnt;
    logic              quiet;

    assign quiet = idle && !req;

    rank_dwell_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (cnt)
    );

    // Next-state and counter control
    always_comb begin
        nxt     = state;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        case (state)
            RS_ACTIVE: begin
                if (!quiet) begin
                    cnt_clr = 1'b1;
                end else if (cnt == idle_lim) begin
                    cnt_clr = 1'b1;
                    if (sr_ok && !bank_open) nxt = RS_SR_ENT;
                    else if (bank_open)      nxt = RS_PD_OPN;
                    else                     nxt = RS_PD_CLS;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            RS_PD_CLS: begin
                if (!quiet || sr_ok) begin
                    nxt     = RS_ACTIVE;
                    cnt_clr = 1'b1;
                end
            end
            RS_PD_OPN: begin
                if (!quiet) begin
                    nxt     = RS_ACTIVE;
                    cnt_clr = 1'b1;
                end
            end
            RS_SR_ENT: begin
                nxt     = RS_SR;
                cnt_clr = 1'b1;
            end
            RS_SR: begin
                if (!quiet || !sr_ok) begin
                    nxt     = RS_SR_EXIT;
                    cnt_clr = 1'b1;
                end
            end
            RS_SR_EXIT: begin
                if (cnt == exit_lim) begin
                    nxt     = RS_ACTIVE;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            default: begin
                nxt     = RS_ACTIVE;
                cnt_clr = 1'b1;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RS_ACTIVE;
        else        state <= nxt;
    end

    // Outputs decoded from the registered state
    always_comb begin
        cke      = !(state == RS_PD_CLS || state == RS_PD_OPN || state == RS_SR);
        ready    = (state == RS_ACTIVE);
        sr_enter = (state == RS_SR_ENT);
        sr_exit  = (state == RS_SR_EXIT) && (cnt == '0);
        case (state)
            RS_PD_CLS: code = CODE_PD_CLS;
            RS_PD_OPN: code = CODE_PD_OPN;
            RS_SR:     code = CODE_SR;
            default:   code = CODE_ACTIVE;
        endcase
    end
endmodule

// File: rtl/rank_cke_ctrl.sv
// DRAM rank power-state controller, top level.
// One power-state machine per rank plus a shared self-refresh
// permission gate. Assumes all inputs are synchronous to clk.
module rank_cke_ctrl
    import rank_cke_pkg::*;
#(
    parameter int NUM_RANKS = 4,
    parameter int IDLE_W    = 8,
    parameter int XLAT_W    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDLE_W-1:0]      idle_limit,
    input  logic [XLAT_W-1:0]      exit_lat,
    input  logic [NUM_RANKS-1:0]   rank_req,
    input  logic [NUM_RANKS-1:0]   rank_idle,
    input  logic [NUM_RANKS-1:0]   bank_open,
    input  logic [2:0]             pkg_state,
    input  logic                   igfx_used,
    input  logic                   gfx_idle,
    input  logic                   disp_pend,
    output logic [NUM_RANKS-1:0]   cke,
    output logic [NUM_RANKS-1:0]   rank_ready,
    output logic [NUM_RANKS-1:0]   sr_enter_req,
    output logic [NUM_RANKS-1:0]   sr_exit_req,
    output logic [2*NUM_RANKS-1:0] pwr_state
);
    localparam int CNT_W = (IDLE_W > XLAT_W) ? IDLE_W : XLAT_W;

    logic             sr_ok;
    logic [CNT_W-1:0] idle_ext;
    logic [CNT_W-1:0] exit_ext;

    // Widen both limits to the shared counter width
    always_comb begin
        idle_ext = CNT_W'(idle_limit);
        exit_ext = CNT_W'(exit_lat);
    end

    rank_sr_gate u_gate (
        .pkg_state (pkg_state),
        .igfx_used (igfx_used),
        .gfx_idle  (gfx_idle),
        .disp_pend (disp_pend),
        .sr_ok     (sr_ok)
    );

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        rank_pwr_fsm #(.CNT_W(CNT_W)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .idle_lim  (idle_ext),
            .exit_lim  (exit_ext),
            .req       (rank_req[r]),
            .idle      (rank_idle[r]),
            .bank_open (bank_open[r]),
            .sr_ok     (sr_ok),
            .cke       (cke[r]),
            .ready     (rank_ready[r]),
            .sr_enter  (sr_enter_req[r]),
            .sr_exit   (sr_exit_req[r]),
            .code      (pwr_state[2*r +: 2])
        );
    end
endmodule

// File: rtl/rank_cke_ctrl_chk.sv
// Property checker for rank_cke_ctrl, attached by bind.
// Observes ports only; one set of properties per rank.
module rank_cke_ctrl_chk #(
    parameter int NUM_RANKS = 4,
    parameter int IDLE_W    = 8,
    parameter int XLAT_W    = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [IDLE_W-1:0]      idle_limit,
    input logic [XLAT_W-1:0]      exit_lat,
    input logic [NUM_RANKS-1:0]   rank_req,
    input logic [NUM_RANKS-1:0]   rank_idle,
    input logic [NUM_RANKS-1:0]   bank_open,
    input logic [2:0]             pkg_state,
    input logic                   igfx_used,
    input logic                   gfx_idle,
    input logic                   disp_pend,
    input logic [NUM_RANKS-1:0]   cke,
    input logic [NUM_RANKS-1:0]   rank_ready,
    input logic [NUM_RANKS-1:0]   sr_enter_req,
    input logic [NUM_RANKS-1:0]   sr_exit_req,
    input logic [2*NUM_RANKS-1:0] pwr_state
);
    logic perm;
    assign perm = (pkg_state >= 3'd3 && pkg_state <= 3'd5) &&
                  (!igfx_used || (gfx_idle && !disp_pend));

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_chk
        // R6: entry request lasts one cycle and CKE is low after it
        assert_enter_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
            sr_enter_req[r] |=> (!cke[r] && !sr_enter_req[r] && pwr_state[2*r +: 2] == 2'd3));

        // R5: an entry request follows a cycle where self-refresh was permitted
        assert_enter_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
            sr_enter_req[r] |-> $past(perm && !bank_open[r]));

        // R4: a ready rank always has CKE high
        assert_ready_cke_R4: assert property (@(posedge clk) disable iff (!rst_n)
            rank_ready[r] |-> cke[r]);

        // R7: the exit request is a single cycle with CKE already high
        assert_exit_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
            sr_exit_req[r] |-> (cke[r] && !rank_ready[r]) ##1 !sr_exit_req[r]);

        // R2: CKE only falls after a quiet cycle or an entry request
        assert_fall_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cke[r]) |-> ($past(rank_idle[r] && !rank_req[r]) || $past(sr_enter_req[r])));

        // R4: traffic to a rank in power-down raises CKE on the next edge
        assert_pd_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!cke[r] && pwr_state[2*r +: 2] != 2'd3 && (rank_req[r] || !rank_idle[r])) |=> cke[r]);
    end
endmodule

bind rank_cke_ctrl rank_cke_ctrl_chk #(
    .NUM_RANKS (NUM_RANKS),
    .IDLE_W    (IDLE_W),
    .XLAT_W    (XLAT_W)
) u_chk (.*);

// File: tb/rank_cke_ctrl_test.sv
`timescale 1ns/1ps
module rank_cke_ctrl_test;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [7:0]     idle_limit = 8'd2;
    logic [7:0]     exit_lat = 8'd2;
    logic [N-1:0]   rank_req = '1;
    logic [N-1:0]   rank_idle = '0;
    logic [N-1:0]   bank_open = '0;
    logic [2:0]     pkg_state = 3'd0;
    logic           igfx_used = 1'b0;
    logic           gfx_idle = 1'b0;
    logic           disp_pend = 1'b0;
    logic [N-1:0]   cke, rank_ready, sr_enter_req, sr_exit_req;
    logic [2*N-1:0] pwr_state;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    rank_cke_ctrl #(.NUM_RANKS(N), .IDLE_W(8), .XLAT_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .idle_limit(idle_limit), .exit_lat(exit_lat),
        .rank_req(rank_req), .rank_idle(rank_idle), .bank_open(bank_open),
        .pkg_state(pkg_state), .igfx_used(igfx_used), .gfx_idle(gfx_idle),
        .disp_pend(disp_pend), .cke(cke), .rank_ready(rank_ready),
        .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req), .pwr_state(pwr_state)
    );

    // Entry: {tag[3:0], stim[8:0], exp[5:0]}
    // stim = req, idle, bank_open, pkg[2:0], igfx_used, gfx_idle, disp_pend (rank 0)
    // exp  = cke, ready, state[1:0], sr_enter, sr_exit (rank 0)
    localparam logic [18:0] VEC [0:57] = '{
        {4'd2, 9'b1_0_0_000_0_0_0, 6'b1_1_00_0_0},  // 0  busy
        {4'd2, 9'b0_1_0_000_0_0_0, 6'b1_1_00_0_0},  // 1  R2 count 1
        {4'd2, 9'b0_1_0_000_0_0_0, 6'b1_1_00_0_0},  // 2  count 2
        {4'd3, 9'b0_1_0_000_0_0_0, 6'b0_0_01_0_0},  // 3  R3 closed-bank power-down
        {4'd5, 9'b0_1_0_000_0_0_0, 6'b0_0_01_0_0},  // 4  R5 C0 keeps power-down
        {4'd4, 9'b1_0_0_000_0_0_0, 6'b1_1_00_0_0},  // 5  R4 request wakes
        {4'd2, 9'b0_1_1_000_0_0_0, 6'b1_1_00_0_0},  // 6
        {4'd2, 9'b0_1_1_000_0_0_0, 6'b1_1_00_0_0},  // 7
        {4'd3, 9'b0_1_1_000_0_0_0, 6'b0_0_10_0_0},  // 8  R3 open-bank power-down
        {4'd4, 9'b0_0_1_000_0_0_0, 6'b1_1_00_0_0},  // 9  R4 busy without request wakes
        {4'd6, 9'b0_1_0_011_0_0_0, 6'b1_1_00_0_0},  // 10 C3
        {4'd6, 9'b0_1_0_011_0_0_0, 6'b1_1_00_0_0},  // 11
        {4'd6, 9'b0_1_0_011_0_0_0, 6'b1_0_00_1_0},  // 12 R6 entry pulse
        {4'd6, 9'b0_1_0_011_0_0_0, 6'b0_0_11_0_0},  // 13 R6 self-refresh
        {4'd6, 9'b0_1_0_011_0_0_0, 6'b0_0_11_0_0},  // 14
        {4'd7, 9'b1_0_0_011_0_0_0, 6'b1_0_00_0_1},  // 15 R7 exit on request
        {4'd7, 9'b1_0_0_011_0_0_0, 6'b1_0_00_0_0},  // 16
        {4'd7, 9'b1_0_0_011_0_0_0, 6'b1_0_00_0_0},  // 17
        {4'd7, 9'b1_0_0_011_0_0_0, 6'b1_1_00_0_0},  // 18 R7 ready after lat+1
        {4'd2, 9'b0_1_0_000_0_0_0, 6'b1_1_00_0_0},  // 19
        {4'd2, 9'b0_1_0_000_0_0_0, 6'b1_1_00_0_0},  // 20
        {4'd3, 9'b0_1_0_000_0_0_0, 6'b0_0_01_0_0},  // 21
        {4'd8, 9'b0_1_0_011_0_0_0, 6'b1_1_00_0_0},  // 22 R8 promotion to active
        {4'd8, 9'b0_1_0_011_0_0_0, 6'b1_1_00_0_0},  // 23
        {4'd8, 9'b0_1_0_011_0_0_0, 6'b1_1_00_0_0},  // 24
        {4'd8, 9'b0_1_0_011_0_0_0, 6'b1_0_00_1_0},  // 25 R8 entry after fresh interval
        {4'd6, 9'b0_1_0_011_0_0_0, 6'b0_0_11_0_0},  // 26
        {4'd7, 9'b0_1_0_001_0_0_0, 6'b1_0_00_0_1},  // 27 R7 exit on C1
        {4'd7, 9'b0_1_0_001_0_0_0, 6'b1_0_00_0_0},  // 28
        {4'd7, 9'b0_1_0_001_0_0_0, 6'b1_0_00_0_0},  // 29
        {4'd7, 9'b0_1_0_001_0_0_0, 6'b1_1_00_0_0},  // 30
        {4'd5, 9'b0_1_0_001_0_0_0, 6'b1_1_00_0_0},  // 31
        {4'd5, 9'b0_1_0_001_0_0_0, 6'b1_1_00_0_0},  // 32
        {4'd5, 9'b0_1_0_001_0_0_0, 6'b0_0_01_0_0},  // 33 R5 C1 gives power-down
        {4'd4, 9'b1_0_0_100_1_0_0, 6'b1_1_00_0_0},  // 34
        {4'd5, 9'b0_1_0_100_1_0_0, 6'b1_1_00_0_0},  // 35 C6, graphics busy
        {4'd5, 9'b0_1_0_100_1_0_0, 6'b1_1_00_0_0},  // 36
        {4'd5, 9'b0_1_0_100_1_0_0, 6'b0_0_01_0_0},  // 37 R5 graphics blocks
        {4'd5, 9'b0_1_0_100_1_1_1, 6'b0_0_01_0_0},  // 38 R5 display blocks
        {4'd8, 9'b0_1_0_100_1_1_0, 6'b1_1_00_0_0},  // 39 R8 permission arrives
        {4'd8, 9'b0_1_0_100_1_1_0, 6'b1_1_00_0_0},  // 40
        {4'd8, 9'b0_1_0_100_1_1_0, 6'b1_1_00_0_0},  // 41
        {4'd6, 9'b0_1_0_100_1_1_0, 6'b1_0_00_1_0},  // 42
        {4'd6, 9'b0_1_0_100_1_1_0, 6'b0_0_11_0_0},  // 43
        {4'd7, 9'b0_1_0_101_1_1_1, 6'b1_0_00_0_1},  // 44 R7 exit on display demand
        {4'd7, 9'b0_1_0_101_1_1_1, 6'b1_0_00_0_0},  // 45
        {4'd7, 9'b0_1_0_101_1_1_1, 6'b1_0_00_0_0},  // 46
        {4'd7, 9'b0_1_0_101_1_1_1, 6'b1_1_00_0_0},  // 47
        {4'd6, 9'b0_1_1_011_0_0_0, 6'b1_1_00_0_0},  // 48
        {4'd6, 9'b0_1_1_011_0_0_0, 6'b1_1_00_0_0},  // 49
        {4'd6, 9'b0_1_1_011_0_0_0, 6'b0_0_10_0_0},  // 50 R6 open bank blocks entry
        {4'd8, 9'b0_1_1_011_0_0_0, 6'b0_0_10_0_0},  // 51 R8 no promotion from open-bank
        {4'd4, 9'b1_0_0_000_0_0_0, 6'b1_1_00_0_0},  // 52
        {4'd2, 9'b0_1_0_000_0_0_0, 6'b1_1_00_0_0},  // 53
        {4'd2, 9'b0_0_0_000_0_0_0, 6'b1_1_00_0_0},  // 54 R2 busy restarts count
        {4'd2, 9'b0_1_0_000_0_0_0, 6'b1_1_00_0_0},  // 55
        {4'd2, 9'b0_1_0_000_0_0_0, 6'b1_1_00_0_0},  // 56
        {4'd2, 9'b0_1_0_000_0_0_0, 6'b0_0_01_0_0}   // 57
    };

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #200000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [5:0] got;
        // R1: reset state
        step(); step();
        check(cke == 4'b1111 && rank_ready == 4'b1111, "R1 cke/ready in reset",
              {cke, rank_ready}, 8'hff);
        check(sr_enter_req == 0 && sr_exit_req == 0 && pwr_state == 0, "R1 requests/state",
              {sr_enter_req, sr_exit_req, pwr_state}, 0);
        rst_n = 1'b1;
        step();
        check(cke == 4'b1111 && rank_ready == 4'b1111, "R1 after release",
              {cke, rank_ready}, 8'hff);

        // Vector walk on rank 0; other ranks held busy
        for (int k = 0; k < 58; k++) begin
            rank_req  = {3'b111, VEC[k][14]};
            rank_idle = {3'b000, VEC[k][13]};
            bank_open = {3'b000, VEC[k][12]};
            pkg_state = VEC[k][11:9];
            igfx_used = VEC[k][8];
            gfx_idle  = VEC[k][7];
            disp_pend = VEC[k][6];
            step();
            got = {cke[0], rank_ready[0], pwr_state[1:0], sr_enter_req[0], sr_exit_req[0]};
            check(got == VEC[k][5:0], $sformatf("R%0d vector %0d", VEC[k][18:15], k),
                  got, VEC[k][5:0]);
        end

        // R9 and R2 boundary: idle_limit 0, only rank 2 goes quiet
        idle_limit = 8'd0;
        rank_req = '1; rank_idle = '0; bank_open = '0; pkg_state = 3'd0;
        igfx_used = 1'b0;
        step();
        check(cke == 4'b1111, "R9 all active", cke, 4'b1111);
        rank_req = 4'b1011; rank_idle = 4'b0100;
        step();
        check(cke == 4'b1011 && pwr_state[5:4] == 2'd1, "R9 rank2 alone in power-down",
              {cke, pwr_state}, {4'b1011, 8'h10});

        // R6/R7 with exit_lat 0 across ranks
        exit_lat = 8'd0;
        rank_req = 4'b0000; rank_idle = 4'b1111; pkg_state = 3'd3;
        step();
        check(sr_enter_req == 4'b1011 && cke == 4'b1111, "R6 entry pulses, R8 rank2 promoted",
              {sr_enter_req, cke}, {4'b1011, 4'b1111});
        step();
        check(sr_enter_req == 4'b0100 && cke == 4'b0100, "R6 rank2 follows one cycle later",
              {sr_enter_req, cke}, {4'b0100, 4'b0100});
        step();
        check(cke == 4'b0000 && pwr_state == 8'hff, "R6 all ranks in self-refresh",
              {cke, pwr_state}, {4'b0000, 8'hff});
        rank_req = 4'b0010; rank_idle = 4'b1101;
        step();
        check(sr_exit_req == 4'b0010 && cke == 4'b0010 && rank_ready == 4'b0000,
              "R7 rank1 exit pulse", {sr_exit_req, cke, rank_ready}, {4'b0010, 4'b0010, 4'b0000});
        step();
        check(rank_ready == 4'b0010 && sr_exit_req == 4'b0000 && cke == 4'b0010,
              "R7 ready after one cycle with zero latency",
              {rank_ready, sr_exit_req, cke}, {4'b0010, 4'b0000, 4'b0010});

        finish_run();
    end
endmodule